// File: doc/BRIEF.md
# Memory-Mapped Serial UART with Parity

This block is an asynchronous serial transmitter and receiver. A processor reaches it through a small register interface. A 2-bit register address, with read and write strobes and an 8-bit data path, selects one of four registers. There is a shared data register: a write sends a character and a read returns the last character received. There is also a status register and a line-format control register. On the line side there is one output wire, which sends, and one input wire, which receives.

The line format is chosen at run time. A character has 7 or 8 data bits, and parity can be none, even or odd. The transmitter wraps each written byte in a start bit, the optional parity bit and a stop bit, then shifts it out. The receiver does several things:

- It synchronises the input wire.
- It finds the falling edge of a start bit and confirms that edge at mid-bit.
- It samples every later bit at its centre, using a 16x oversampling tick taken from a parameterised clock divider.
- It places the finished character in a single holding register, together with parity, framing and overrun flags.

Top module: `uart_mmio`

## Requirements
- R1: After reset the output line is 1, the status register reads 0x00, and the line rests at 1 whenever no frame is being sent.
- R2: Address 0 is written to send a byte and read to fetch the received byte. Address 1 is status. Address 2 is control. Address 3 reads 0x00.
  - Status bits: bit0 = receive data available, bit1 = transmitter busy, bit2 = parity error, bit3 = framing error, bit4 = overrun. Bits 7:5 always read 0.
  - Control bits: bit0 = 8 data bits (0 selects 7), bit1 = parity enable, bit2 = odd parity (0 selects even). Control resets to 0x01.
- R3: A transmitted frame is sent in this order: a start bit of 0, the data bits least significant first, the parity bit if enabled, and a stop bit of 1. Each bit lasts 16*CLK_DIV clock cycles.
- R4: Parity is chosen so that the count of ones in the data bits plus the parity bit is even under even parity and odd under odd parity.
- R5: In 7-bit mode only data bits 6:0 are sent or received, and bit 7 of the received data reads 0.
- R6: A write to address 0 while the transmitter is idle starts a frame and sets the busy bit until the stop bit ends. A write while busy is ignored.
- R7: A completed received character is placed in the receive register and sets data-available. Reading address 0 clears data-available.
- R8: A low pulse on the input line shorter than half a bit is rejected as a false start and produces no character.
- R9: A received parity bit that does not match the data sets the parity-error flag. Reading address 0 clears it.
- R10: A 0 sampled where the stop bit belongs sets the framing-error flag. Reading address 0 clears it.
- R11: A character that completes while data-available is still set sets the overrun flag and replaces the held character. Reading address 0 clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register while reg_rd is high, else 0 |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |

## Verification
The bench builds the block with CLK_DIV = 2. One bit therefore lasts 32 clocks and a full 11-bit frame about 350 cycles. This makes it practical to run every combination of width and parity, plus error frames, back-to-back overrun frames and short start glitches, all in one run. The bench drives and decodes the serial line with its own bit timing. It computes the expected parity by counting ones, so the oversampling centre and the frame order are checked against an independent model of the line.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  localparam int OVS       = 16;
  localparam int FRAME_MAX = 11;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic eight;
  } line_cfg_t;

  // Parity bit that makes the total count of ones even (odd=0) or odd (odd=1).
  function automatic logic parity_of(input logic [7:0] d, input logic eight, input logic odd);
    logic [7:0] m;
    m = eight ? d : {1'b0, d[6:0]};
    return (^m) ^ odd;
  endfunction

  function automatic logic [3:0] frame_len(input line_cfg_t c);
    return 4'd9 + {3'b000, c.eight} + {3'b000, c.par_en};
  endfunction

  // Frame bits in send order, element 0 first; unused tail stays at 1.
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [7:0] d, input line_cfg_t c);
    logic [FRAME_MAX-1:0] f;
    int pos;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || c.eight) f[1+i] = d[i];
    end
    pos = c.eight ? 9 : 8;
    if (c.par_en) f[pos] = parity_of(d, c.eight, c.par_odd);
    return f;
  endfunction
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int CLK_DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(CLK_DIV);
      logic [CW-1:0] cnt;
      assign tick = (cnt == CW'(CLK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_mmio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [3:0]           len,
  output logic                 busy,
  output logic                 line
);
  localparam int SW = $clog2(OVS);

  logic [FRAME_MAX-1:0] sh;
  logic [3:0]           bits_left;
  logic [SW-1:0]        sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      sub       <= '0;
    end else if (load && !busy) begin
      busy      <= 1'b1;
      sh        <= frame;
      bits_left <= len;
      sub       <= '0;
    end else if (busy && tick) begin
      if (sub == SW'(OVS - 1)) begin
        sub       <= '0;
        sh        <= {1'b1, sh[FRAME_MAX-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == 4'd1) busy <= 1'b0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign line = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_mmio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      line_in,
  input  line_cfg_t cfg,
  output logic      done,
  output logic [7:0] data,
  output logic      par_err,
  output logic      frm_err
);
  localparam int SW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_e;

  rx_state_e   st;
  logic [1:0]  sync;
  logic        rx_s;
  logic        prev;
  logic [SW-1:0] cnt;
  logic [2:0]  idx;
  logic [7:0]  shreg;
  logic        par_bit;
  logic [2:0]  last_idx;
  logic        at_centre;

  assign rx_s      = sync[1];
  assign last_idx  = cfg.eight ? 3'd7 : 3'd6;
  assign at_centre = (cnt == SW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      prev    <= 1'b1;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= rx_s;
        case (st)
          S_IDLE: begin
            if (prev && !rx_s) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == SW'(HALF - 2)) begin
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
              st    <= rx_s ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (at_centre) begin
              cnt        <= '0;
              shreg[idx] <= rx_s;
              if (idx == last_idx) st <= cfg.par_en ? S_PAR : S_STOP;
              else                 idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (at_centre) begin
              cnt     <= '0;
              par_bit <= rx_s;
              st      <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (at_centre) begin
              cnt     <= '0;
              done    <= 1'b1;
              data    <= shreg;
              par_err <= cfg.par_en && (par_bit != parity_of(shreg, cfg.eight, cfg.par_odd));
              frm_err <= !rx_s;
              st      <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int CLK_DIV = 27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ser_in,
  output logic       ser_out
);
  logic      tick;
  line_cfg_t cfg;
  logic      tx_busy;
  logic      tx_accept;
  logic      rd_rx;
  logic      rx_done;
  logic [7:0] rx_data;
  logic      rx_perr;
  logic      rx_ferr;
  logic [7:0] rx_hold;
  logic      rx_avail;
  logic      perr_flag;
  logic      ferr_flag;
  logic      ovr_flag;

  assign tx_accept = reg_wr && (reg_addr == REG_DATA) && !tx_busy;
  assign rd_rx     = reg_rd && (reg_addr == REG_DATA);

  uart_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  uart_tx_engine u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_accept),
    .frame(build_frame(reg_wdata, cfg)), .len(frame_len(cfg)),
    .busy(tx_busy), .line(ser_out)
  );

  uart_rx_engine u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(ser_in), .cfg(cfg),
    .done(rx_done), .data(rx_data), .par_err(rx_perr), .frm_err(rx_ferr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= 3'b001;
    else if (reg_wr && reg_addr == REG_CTRL) cfg <= reg_wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold   <= '0;
      rx_avail  <= 1'b0;
      perr_flag <= 1'b0;
      ferr_flag <= 1'b0;
      ovr_flag  <= 1'b0;
    end else if (rx_done) begin
      rx_hold   <= rx_data;
      rx_avail  <= 1'b1;
      perr_flag <= (perr_flag && !rd_rx) || rx_perr;
      ferr_flag <= (ferr_flag && !rd_rx) || rx_ferr;
      ovr_flag  <= (ovr_flag && !rd_rx) || (rx_avail && !rd_rx);
    end else if (rd_rx) begin
      rx_avail  <= 1'b0;
      perr_flag <= 1'b0;
      ferr_flag <= 1'b0;
      ovr_flag  <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_sel_e'(reg_addr))
        REG_DATA: reg_rdata = rx_hold;
        REG_STAT: reg_rdata = {3'b000, ovr_flag, ferr_flag, perr_flag, tx_busy, rx_avail};
        REG_CTRL: reg_rdata = {5'b00000, cfg};
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_mmio_checker.sv
module uart_mmio_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic       ser_out,
  input logic       tx_busy,
  input logic       tx_accept,
  input logic       rx_done,
  input logic       rx_avail,
  input logic       ovr_flag
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_out);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1) |-> (reg_rdata[7:5] == 3'b000));

  assert_busy_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_accept));

  assert_done_sets_avail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_avail);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && !rx_done) |=> !rx_avail);

  assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_avail && !(reg_rd && reg_addr == 2'd0)) |=> ovr_flag);
endmodule

bind uart_mmio uart_mmio_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .ser_out(ser_out), .tx_busy(tx_busy),
  .tx_accept(tx_accept), .rx_done(rx_done), .rx_avail(rx_avail),
  .ovr_flag(ovr_flag)
);

// File: tb/uart_mmio_bench.sv
module uart_mmio_bench;
  localparam int CLK_DIV = 2;
  localparam int BIT     = 16 * CLK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ser_in = 1'b1;
  logic       ser_out;

  int checks = 0;
  int errors = 0;
  bit cfg_eight = 1'b1, cfg_pen = 1'b0, cfg_odd = 1'b0;
  logic [10:0] exp_frame[$];
  int          exp_len[$];

  always #10 clk = ~clk;

  uart_mmio #(.CLK_DIV(CLK_DIV)) u_uart_mmio (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_in(ser_in), .ser_out(ser_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_cfg(input bit eight, input bit pen, input bit odd);
    cfg_eight = eight; cfg_pen = pen; cfg_odd = odd;
    bus_write(2'd2, {5'b0, odd, pen, eight});
  endtask

  function automatic bit ones_parity(input logic [7:0] d, input int n, input bit odd);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    return ((ones % 2) == 1) ^ odd;
  endfunction

  // Driver: predict the line frame (R3, R4, R5), push it, then write.
  task automatic send_tx(input logic [7:0] d);
    logic [10:0] f = '1;
    int n = cfg_eight ? 8 : 7;
    int p = 0;
    f[p++] = 1'b0;
    for (int i = 0; i < n; i++) f[p++] = d[i];
    if (cfg_pen) f[p++] = ones_parity(d, n, cfg_odd);
    f[p++] = 1'b1;
    exp_frame.push_back(f);
    exp_len.push_back(p);
    bus_write(2'd0, d);
  endtask

  // Monitor: decode the output line at bit centres and compare.
  initial begin
    forever begin
      @(negedge clk);
      if (ser_out === 1'b0) begin
        logic [10:0] got = '1;
        logic [10:0] want;
        int len;
        repeat (BIT/2) @(negedge clk);
        got[0] = ser_out;
        if (exp_frame.size() == 0) begin
          check(1'b0, "R6 unexpected frame", 1, 0);
          len = 10;
          want = '1;
        end else begin
          want = exp_frame.pop_front();
          len = exp_len.pop_front();
        end
        for (int k = 1; k < len; k++) begin
          repeat (BIT) @(negedge clk);
          got[k] = ser_out;
        end
        check(got == want, "R3/R4 tx frame", int'(got), int'(want));
        while (ser_out !== 1'b1) @(negedge clk);
      end
    end
  end

  task automatic drive_rx(input logic [7:0] d, input int n, input bit pen, input bit odd,
                          input bit flip_par, input bit bad_stop);
    @(negedge clk);
    ser_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ser_in = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (pen) begin
      ser_in = ones_parity(d, n, odd) ^ flip_par;
      repeat (BIT) @(negedge clk);
    end
    ser_in = !bad_stop;
    repeat (BIT) @(negedge clk);
    ser_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(2'd1, s);
      if (!s[1]) break;
    end
    repeat (BIT) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R2 reset state
    check(ser_out === 1'b1, "R1 idle line", int'(ser_out), 1);
    bus_read(2'd1, v); check(v == 8'h00, "R1 status after reset", v, 8'h00);
    bus_read(2'd2, v); check(v == 8'h01, "R2 control reset", v, 8'h01);
    bus_read(2'd3, v); check(v == 8'h00, "R2 unused address", v, 8'h00);

    // R6 busy and ignored write, R3 8N1 frame
    send_tx(8'hA5);
    bus_read(2'd1, v); check(v[1] == 1'b1, "R6 busy after write", v, 8'h02);
    bus_write(2'd0, 8'h99);
    bus_read(2'd1, v); check(v[1] == 1'b1, "R6 still busy", v, 8'h02);
    wait_tx_idle();
    check(exp_frame.size() == 0, "R6 queue drained", exp_frame.size(), 0);
    bus_read(2'd1, v); check(v[1] == 1'b0, "R6 busy cleared", v, 8'h00);

    // R4 even parity, 8 bits
    set_cfg(1'b1, 1'b1, 1'b0);
    send_tx(8'h31); wait_tx_idle();
    // R4 R5 odd parity, 7 bits, bit 7 not sent
    set_cfg(1'b0, 1'b1, 1'b1);
    send_tx(8'hC5); wait_tx_idle();
    // R5 7 bits, no parity
    set_cfg(1'b0, 1'b0, 1'b0);
    send_tx(8'h80); wait_tx_idle();
    check(exp_frame.size() == 0, "R3 all frames seen", exp_frame.size(), 0);

    // R7 receive 8N1
    set_cfg(1'b1, 1'b0, 1'b0);
    drive_rx(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_read(2'd1, v); check(v == 8'h01, "R7 available", v, 8'h01);
    bus_read(2'd0, v); check(v == 8'h3C, "R7 data", v, 8'h3C);
    bus_read(2'd1, v); check(v == 8'h00, "R7 cleared by read", v, 8'h00);

    // R5 receive 7 bits even parity
    set_cfg(1'b0, 1'b1, 1'b0);
    drive_rx(8'h7F, 7, 1'b1, 1'b0, 1'b0, 1'b0);
    bus_read(2'd1, v); check(v == 8'h01, "R5 7-bit status", v, 8'h01);
    bus_read(2'd0, v); check(v == 8'h7F, "R5 7-bit data", v, 8'h7F);

    // R9 parity error with odd parity
    set_cfg(1'b1, 1'b1, 1'b1);
    drive_rx(8'h55, 8, 1'b1, 1'b1, 1'b1, 1'b0);
    bus_read(2'd1, v); check(v == 8'h05, "R9 parity error", v, 8'h05);
    drive_rx(8'h56, 8, 1'b1, 1'b1, 1'b0, 1'b0);
    bus_read(2'd0, v); check(v == 8'h56, "R11 replaced data", v, 8'h56);
    bus_read(2'd1, v); check(v == 8'h00, "R9 cleared by read", v, 8'h00);

    // R10 framing error
    set_cfg(1'b1, 1'b0, 1'b0);
    drive_rx(8'h0F, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    bus_read(2'd1, v); check(v == 8'h09, "R10 framing error", v, 8'h09);
    bus_read(2'd0, v); check(v == 8'h0F, "R10 data", v, 8'h0F);
    bus_read(2'd1, v); check(v == 8'h00, "R10 cleared by read", v, 8'h00);

    // R11 overrun
    drive_rx(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    drive_rx(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_read(2'd1, v); check(v == 8'h11, "R11 overrun status", v, 8'h11);
    bus_read(2'd0, v); check(v == 8'h22, "R11 newest data", v, 8'h22);
    bus_read(2'd1, v); check(v == 8'h00, "R11 cleared by read", v, 8'h00);

    // R8 start glitch
    @(negedge clk); ser_in = 1'b0;
    repeat (6) @(negedge clk); ser_in = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    bus_read(2'd1, v); check(v == 8'h00, "R8 glitch rejected", v, 8'h00);
    drive_rx(8'h6B, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_read(2'd0, v); check(v == 8'h6B, "R8 frame after glitch", v, 8'h6B);

    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule